// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between a 64-bit host register port and a small bank of 8-bit registers inside a two-wire bus controller. The host never addresses the inner registers directly. It writes one command word that holds a start flag, an operation code, a read flag, a register selector and a data byte. The bridge then runs the access against the controller's register port. On a read it places the returned byte in the low byte of the same word. When the access is done it drops the start flag, which now serves as a busy indicator, so the host polls the word to learn when the access has finished.

A second host register controls the controller's interrupt and two line-override outputs. The override outputs let software wiggle the clock line and then the data line to free a bus that a target is holding low. The interrupt asserts while the controller's status byte differs from the idle code.

Top module: `regbank_cmd_bridge`

## Requirements
- R1: After reset, both host registers read back as zero, and `irq`, `ovr_scl`, `ovr_sda` and `eng_wr` are low.
- R2: A host write to offset 0x00 with bit 63 set, made while no access is running, starts an access. Bit 63 of the command word reads 1 from the accepting clock edge until the fourth edge after it, and reads 0 from that edge on.
- R3: The command word reads back with these fields: bit 63 busy, bits 59:57 operation, bit 56 read flag, bits 34:32 selector, bits 7:0 data. Every other bit reads 0, whatever was written there.
- R4: Operation 3'b110 (0xC or 0xD in bits 59:56) is an extended access. Selectors 1, 2 and 3 may be read or written. Selector 7 (soft reset) may only be written. A legal write raises `eng_wr` for exactly one cycle, the last cycle of the access, with `eng_addr` = {0, selector} and `eng_wdata` = the data byte.
- R5: Operation 3'b100 (0x8 in bits 59:56) reaches the clock high-period divider at `eng_addr` = 4'b1000, whatever the selector bits hold.
- R6: On a legal read, `eng_is_read` is high during the access, and the byte on `eng_rdata` in the last cycle of the access appears in bits 7:0 of the command word once busy has cleared. On a write, bits 7:0 keep the written byte.
- R7: Any other combination of operation, read flag and selector still runs the full four-cycle access. It raises no `eng_wr`, and a read of this kind returns 0 in bits 7:0.
- R8: A command write made while an access is running, or made with bit 63 clear, is ignored. No access starts, no `eng_wr` appears, and the readback of the command word is unchanged.
- R9: The register at offset 0x10 holds an interrupt enable in bit 6. `irq` is registered: one cycle after any change, it equals enable AND (`eng_status` != 0xF8).
- R10: Bits 9 and 8 of the offset 0x10 register drive `ovr_scl` and `ovr_sda` from the accepting edge. A readback of that register returns bits 9, 8 and 6 exactly as written, and 0 in all other bits.
- R11: Host writes to any offset other than 0x00 and 0x10 change neither register and start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Readback of the register at `host_addr` (combinational) |
| eng_wr | output | 1 | One-cycle write strobe to the controller register port |
| eng_is_read | output | 1 | High while a read access is running |
| eng_addr | output | 4 | Inner register address: {divider flag, selector} |
| eng_wdata | output | 8 | Byte to be written to the inner register |
| eng_rdata | input | 8 | Byte read from the inner register at `eng_addr` |
| eng_status | input | 8 | Current controller status byte |
| irq | output | 1 | Interrupt request |
| ovr_scl | output | 1 | Clock-line manual override |
| ovr_sda | output | 1 | Data-line manual override |

## Verification
Each command word is counted from the edge that accepts it. Busy is sampled just after that edge and after each of the next four edges. The bench expects the value 1, 1, 1, 1 and then 0. The engine strobe is due only in the sample taken after the third edge, and the read byte and the final readback are checked only after the fourth edge. The interrupt output lags its enable and status inputs by one edge, so every `irq` check waits one cycle after the stimulus. Override outputs and interrupt-register readback are checked right after the accepting edge. The bench drives every stimulus and takes every sample at the falling edge, so no check falls on the edge where a value is changing.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  localparam int WORD_W     = 64;
  localparam int BYTE_W     = 8;
  localparam int OP_W       = 3;
  localparam int SEL_W      = 3;
  localparam int NUM_SEL    = 1 << SEL_W;
  localparam int ENG_ADDR_W = SEL_W + 1;

  // command word field positions (decoded by software, so fixed)
  localparam int BUSY_BIT = 63;
  localparam int OP_LO    = 57;
  localparam int RD_BIT   = 56;
  localparam int SEL_LO   = 32;

  // interrupt / override register bit positions
  localparam int IEN_BIT  = 6;
  localparam int OSDA_BIT = 8;
  localparam int OSCL_BIT = 9;

  localparam logic [OP_W-1:0] OP_EXT = 3'b110;
  localparam logic [OP_W-1:0] OP_DIV = 3'b100;

  localparam int SEL_DATA  = 1;
  localparam int SEL_CTRL  = 2;
  localparam int SEL_CLKST = 3;
  localparam int SEL_RESET = 7;

  localparam logic [ENG_ADDR_W-1:0] DIV_ADDR = ENG_ADDR_W'(1 << SEL_W);
  localparam logic [BYTE_W-1:0]     IDLE_CODE = 8'hF8;

  typedef struct packed {
    logic              rd;
    logic [OP_W-1:0]   op;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/rcb_rst_sync.sv
module rcb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rcb_cmd_decode.sv
module rcb_cmd_decode
  import rcb_pkg::*;
(
  input  cmd_t                  cmd_i,
  output logic                  legal_o,
  output logic [ENG_ADDR_W-1:0] eng_addr_o
);

  logic [NUM_SEL-1:0] rd_ok;
  logic [NUM_SEL-1:0] wr_ok;

  // per-selector permission table
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    localparam bit READABLE = (g == SEL_DATA) || (g == SEL_CTRL) || (g == SEL_CLKST);
    localparam bit WRITABLE = READABLE || (g == SEL_RESET);
    assign rd_ok[g] = READABLE;
    assign wr_ok[g] = WRITABLE;
  end

  logic is_ext;
  logic is_div;
  logic sel_ok;

  always_comb begin
    is_ext  = (cmd_i.op == OP_EXT);
    is_div  = (cmd_i.op == OP_DIV);
    sel_ok  = cmd_i.rd ? rd_ok[cmd_i.sel] : wr_ok[cmd_i.sel];
    legal_o = is_div || (is_ext && sel_ok);
    if (is_div) begin
      eng_addr_o = DIV_ADDR;
    end else begin
      eng_addr_o = {1'b0, cmd_i.sel};
    end
  end

endmodule

// File: rtl/rcb_access_seq.sv
module rcb_access_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);

  localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LAT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seq_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST_CNT) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign seq_en = start_i || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == LAST_CNT);

endmodule

// File: rtl/rcb_intr_ovr.sv
module rcb_intr_ovr
  import rcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              irq_o,
  output logic              ovr_scl_o,
  output logic              ovr_sda_o,
  output logic [WORD_W-1:0] rdata_o
);

  logic ien_q, scl_q, sda_q;
  logic irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else if (wr_i) begin
      ien_q <= wdata_i[IEN_BIT];
      scl_q <= wdata_i[OSCL_BIT];
      sda_q <= wdata_i[OSDA_BIT];
    end
  end

  always_comb begin
    irq_d = ien_q && (status_i != IDLE_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[IEN_BIT]  = ien_q;
    rdata_o[OSCL_BIT] = scl_q;
    rdata_o[OSDA_BIT] = sda_q;
  end

  assign irq_o     = irq_q;
  assign ovr_scl_o = scl_q;
  assign ovr_sda_o = sda_q;

endmodule

// File: rtl/regbank_cmd_bridge.sv
module regbank_cmd_bridge
  import rcb_pkg::*;
#(
  parameter int              ADDR_W  = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS = 5'h00,
  parameter logic [ADDR_W-1:0] INT_OFS = 5'h10,
  parameter int              LAT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              eng_wr,
  output logic              eng_is_read,
  output logic [3:0]        eng_addr,
  output logic [7:0]        eng_wdata,
  input  logic [7:0]        eng_rdata,
  input  logic [7:0]        eng_status,
  output logic              irq,
  output logic              ovr_scl,
  output logic              ovr_sda
);

  logic rst_q_n;

  rcb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // host write decode
  logic cmd_hit, int_hit, start;
  logic busy, last;

  assign cmd_hit = host_wr_en && (host_addr == CMD_OFS);
  assign int_hit = host_wr_en && (host_addr == INT_OFS);
  assign start   = cmd_hit && host_wdata[BUSY_BIT] && !busy;

  rcb_access_seq #(.LAT(LAT)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start_i (start),
    .busy_o  (busy),
    .last_o  (last)
  );

  // command register: next-state and storage
  cmd_t cmd_q, cmd_d, cmd_in;
  logic cmd_en;
  logic legal;
  logic [ENG_ADDR_W-1:0] dec_addr;

  always_comb begin
    cmd_in.rd   = host_wdata[RD_BIT];
    cmd_in.op   = host_wdata[OP_LO +: OP_W];
    cmd_in.sel  = host_wdata[SEL_LO +: SEL_W];
    cmd_in.data = host_wdata[BYTE_W-1:0];
  end

  rcb_cmd_decode u_dec (
    .cmd_i      (cmd_q),
    .legal_o    (legal),
    .eng_addr_o (dec_addr)
  );

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    if (start) begin
      cmd_d  = cmd_in;
      cmd_en = 1'b1;
    end else if (last && cmd_q.rd) begin
      cmd_d.data = legal ? eng_rdata : '0;
      cmd_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  // controller register port
  assign eng_addr    = dec_addr;
  assign eng_wdata   = cmd_q.data;
  assign eng_wr      = last && !cmd_q.rd && legal;
  assign eng_is_read = busy && cmd_q.rd;

  // interrupt and line overrides
  logic [WORD_W-1:0] int_rdata;

  rcb_intr_ovr u_int (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_i      (int_hit),
    .wdata_i   (host_wdata),
    .status_i  (eng_status),
    .irq_o     (irq),
    .ovr_scl_o (ovr_scl),
    .ovr_sda_o (ovr_sda),
    .rdata_o   (int_rdata)
  );

  // readback mux
  logic [WORD_W-1:0] cmd_rdata;

  always_comb begin
    cmd_rdata                      = '0;
    cmd_rdata[BUSY_BIT]            = busy;
    cmd_rdata[OP_LO +: OP_W]       = cmd_q.op;
    cmd_rdata[RD_BIT]              = cmd_q.rd;
    cmd_rdata[SEL_LO +: SEL_W]     = cmd_q.sel;
    cmd_rdata[BYTE_W-1:0]          = cmd_q.data;
  end

  always_comb begin
    if (host_addr == CMD_OFS) begin
      host_rdata = cmd_rdata;
    end else if (host_addr == INT_OFS) begin
      host_rdata = int_rdata;
    end else begin
      host_rdata = '0;
    end
  end

endmodule

// File: rtl/regbank_cmd_bridge_chk.sv
module regbank_cmd_bridge_chk #(
  parameter int                ADDR_W  = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS = 5'h00,
  parameter logic [ADDR_W-1:0] INT_OFS = 5'h10,
  parameter int                LAT     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic [63:0]       host_rdata,
  input logic              eng_wr,
  input logic [3:0]        eng_addr,
  input logic [7:0]        eng_status,
  input logic              irq,
  input logic              ovr_scl,
  input logic              ovr_sda
);

  localparam logic [63:0] UNUSED_MASK = 64'h70FF_FFF8_FFFF_FF00;

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 8'd1;
    end else begin
      run_q <= '0;
    end
  end

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (run_q < 8'(LAT - 1))) |=> busy);

  a_r2_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (run_q == 8'(LAT - 1))) |=> !busy);

  a_r4_strobe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |-> busy);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |=> !eng_wr);

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(eng_addr));

  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == CMD_OFS) |-> ((host_rdata & UNUSED_MASK) == 64'd0));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_status == 8'hF8) |=> !irq);

  a_r10_ovr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_en && (host_addr == INT_OFS)) |=> ($stable(ovr_scl) && $stable(ovr_sda)));

endmodule

bind regbank_cmd_bridge regbank_cmd_bridge_chk #(
  .ADDR_W (ADDR_W),
  .CMD_OFS(CMD_OFS),
  .INT_OFS(INT_OFS),
  .LAT    (LAT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .busy       (busy),
  .host_wr_en (host_wr_en),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .eng_wr     (eng_wr),
  .eng_addr   (eng_addr),
  .eng_status (eng_status),
  .irq        (irq),
  .ovr_scl    (ovr_scl),
  .ovr_sda    (ovr_sda)
);

// File: tb/regbank_cmd_bridge_tb_top.sv
`timescale 1ns/1ps
module regbank_cmd_bridge_tb_top;

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [4:0]  host_addr;
  logic [63:0] host_wdata;
  logic [63:0] host_rdata;
  logic        eng_wr;
  logic        eng_is_read;
  logic [3:0]  eng_addr;
  logic [7:0]  eng_wdata;
  logic [7:0]  eng_rdata;
  logic [7:0]  eng_status;
  logic        irq;
  logic        ovr_scl;
  logic        ovr_sda;

  int  n_tests;
  int  n_fail;
  bit  done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  regbank_cmd_bridge dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_wr     (eng_wr),
    .eng_is_read(eng_is_read),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .eng_rdata  (eng_rdata),
    .eng_status (eng_status),
    .irq        (irq),
    .ovr_scl    (ovr_scl),
    .ovr_sda    (ovr_sda)
  );

  // controller register bank model
  logic [7:0] bank [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'(8'h13 + 8'(i * 29));
    end else if (eng_wr) begin
      bank[eng_addr] <= eng_wdata;
    end
  end

  assign eng_rdata = (eng_addr == 4'd3 && eng_is_read) ? eng_status : bank[eng_addr];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [63:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [63:0] mk_cmd(input logic v, input logic [2:0] op, input logic rd,
                                         input logic [2:0] sel, input logic [7:0] data,
                                         input logic junk);
    logic [63:0] w;
    w = junk ? 64'h70FF_FFF8_FFFF_FF00 : 64'd0;
    w[63]    = v;
    w[59:57] = op;
    w[56]    = rd;
    w[34:32] = sel;
    w[7:0]   = data;
    return w;
  endfunction

  // runs one accepted command, checks busy window; returns strobe count
  task automatic run_cmd(input logic [63:0] w, output int pulses);
    logic [63:0] r;
    pulses = 0;
    host_write(5'h00, w);
    peek(5'h00, r);
    chk("R2 busy after accept", {63'd0, r[63]}, 64'd1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (eng_wr) pulses++;
      peek(5'h00, r);
      chk(k < 4 ? "R2 busy held" : "R2 busy cleared", {63'd0, r[63]}, (k < 4) ? 64'd1 : 64'd0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] r, prev;
    int pulses;
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n      = 1'b0;
    host_wr_en = 1'b0;
    host_addr  = 5'h00;
    host_wdata = '0;
    eng_status = 8'h2C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(5'h00, r); chk("R1 cmd reset", r, 64'd0);
    peek(5'h10, r); chk("R1 int reset", r, 64'd0);
    chk("R1 outputs reset", {60'd0, irq, ovr_scl, ovr_sda, eng_wr}, 64'd0);

    // R3-R7 sweep of every op/read/selector combination, junk in unused bits
    for (int op = 0; op < 8; op++) begin
      for (int rd = 0; rd < 2; rd++) begin
        for (int sel = 0; sel < 8; sel++) begin
          logic legal;
          logic [3:0] ea;
          logic [7:0] d, dexp;
          d  = 8'((op * 16 + sel * 2 + rd) ^ 8'h5A);
          legal = (op == 4) || (op == 6 && ((sel >= 1 && sel <= 3) || (sel == 7 && rd == 0)));
          ea = (op == 4) ? 4'd8 : {1'b0, 3'(sel)};
          if (rd == 1) begin
            if (!legal) dexp = 8'd0;
            else if (ea == 4'd3) dexp = eng_status;
            else dexp = bank[ea];
          end else begin
            dexp = d;
          end
          run_cmd(mk_cmd(1'b1, 3'(op), 1'(rd), 3'(sel), d, 1'b1), pulses);
          chk(rd == 1 ? "R7 no strobe on read" : (legal ? "R4 R5 one strobe" : "R7 no strobe"),
              64'(pulses), (legal && rd == 0) ? 64'd1 : 64'd0);
          if (legal && rd == 0) chk("R4 R5 engine write data", {56'd0, bank[ea]}, {56'd0, d});
          peek(5'h00, r);
          chk(rd == 1 ? "R6 R7 R3 read readback" : "R3 write readback", r,
              mk_cmd(1'b0, 3'(op), 1'(rd), 3'(sel), dexp, 1'b0));
        end
      end
    end

    // R8 write during busy is ignored
    begin
      logic [7:0] b2;
      b2 = bank[2];
      host_write(5'h00, mk_cmd(1'b1, 3'b110, 1'b0, 3'd1, 8'hA1, 1'b0));
      host_write(5'h00, mk_cmd(1'b1, 3'b110, 1'b0, 3'd2, 8'hB2, 1'b0));
      peek(5'h00, r);
      chk("R8 fields kept during busy", r, mk_cmd(1'b1, 3'b110, 1'b0, 3'd1, 8'hA1, 1'b0));
      repeat (3) @(negedge clk);
      peek(5'h00, r);
      chk("R8 first command completes", r, mk_cmd(1'b0, 3'b110, 1'b0, 3'd1, 8'hA1, 1'b0));
      chk("R8 first write landed", {56'd0, bank[1]}, 64'hA1);
      chk("R8 second write dropped", {56'd0, bank[2]}, {56'd0, b2});
    end

    // R8 write with start flag clear is ignored
    begin
      peek(5'h00, prev);
      pulses = 0;
      host_write(5'h00, mk_cmd(1'b0, 3'b110, 1'b0, 3'd1, 8'h77, 1'b0));
      for (int k = 0; k < 4; k++) begin
        if (eng_wr) pulses++;
        @(negedge clk);
      end
      peek(5'h00, r);
      chk("R8 clear flag no access", r, prev);
      chk("R8 clear flag no strobe", 64'(pulses), 64'd0);
      chk("R8 clear flag bank intact", {56'd0, bank[1]}, 64'hA1);
    end

    // R9 interrupt
    eng_status = 8'h2C;
    host_write(5'h10, 64'h40);
    peek(5'h10, r); chk("R10 readback 0x40", r, 64'h40);
    @(negedge clk);
    chk("R9 irq with busy status", {63'd0, irq}, 64'd1);
    eng_status = 8'hF8;
    @(negedge clk);
    chk("R9 irq off at idle code", {63'd0, irq}, 64'd0);
    eng_status = 8'h08;
    @(negedge clk);
    chk("R9 irq back on", {63'd0, irq}, 64'd1);
    host_write(5'h10, 64'h0);
    @(negedge clk);
    chk("R9 irq off when disabled", {63'd0, irq}, 64'd0);

    // R10 line overrides in recovery order
    host_write(5'h10, 64'h200);
    peek(5'h10, r); chk("R10 readback 0x200", r, 64'h200);
    chk("R10 scl only", {62'd0, ovr_scl, ovr_sda}, 64'd2);
    host_write(5'h10, 64'h300);
    peek(5'h10, r); chk("R10 readback 0x300", r, 64'h300);
    chk("R10 both", {62'd0, ovr_scl, ovr_sda}, 64'd3);
    host_write(5'h10, 64'h100);
    peek(5'h10, r); chk("R10 readback 0x100", r, 64'h100);
    chk("R10 sda only", {62'd0, ovr_scl, ovr_sda}, 64'd1);
    host_write(5'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(5'h10, r); chk("R10 unused bits zero", r, 64'h340);

    // R11 other offsets
    peek(5'h00, prev);
    host_write(5'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(5'h00, r); chk("R11 cmd untouched", r, prev);
    peek(5'h10, r); chk("R11 int untouched", r, 64'h340);
    host_write(5'h18, 64'h0);
    peek(5'h10, r); chk("R11 int still untouched", r, 64'h340);
    chk("R11 overrides unchanged", {62'd0, ovr_scl, ovr_sda}, 64'd3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule